// File: doc/BRIEF.md
# Two-Read One-Write Register File

This block holds a small bank of general-purpose registers for a datapath. One write port stores a data word into the register picked by its select lines at a rising clock edge, provided the write enable is high. Two read ports, each with its own select, show the contents of the chosen registers through multiplexers. The read ports have no enable and no clock.

A write is not forwarded to the read ports. If a read port selects the register being written, it shows the old contents for the rest of that cycle and shows the new word only after the edge. An active-high synchronous reset clears the whole bank at a clock edge. Reset wins over a write presented in the same cycle.

The bank is made of one reusable single-register module, repeated once per entry. A one-hot write decoder and a read multiplexer per port sit around the registers. The word width and the register count are parameters. The default is eight registers of 16 bits, and the same code builds 32- or 64-bit banks.

The block has no state machine. Its only states are the two conditions of each register:
- cleared, entered on reset;
- loaded, entered on a write.

The transitions are:
- reset, which moves any register to cleared;
- write-hit, which loads the selected register;
- hold, which applies to every other register.

Top module: `regbank_2r1w`

## Requirements
- R1: When `rst` is high at a rising edge, every register becomes zero, and both read ports then show 0 for every select value.
- R2: When `wr_en` is high and `rst` is low at a rising edge, the register whose index equals `wr_sel` (binary, 0 to 7) takes `wr_data`.
- R3: A register that is not selected for writing, or any register while `wr_en` is low, keeps its value across the edge, whatever `wr_data` and `wr_sel` carry.
- R4: Each read port is combinational: a change of `rdA_sel` or `rdB_sel` shows the selected register's contents on the matching data output without a clock edge.
- R5: There is no bypass. During the cycle in which a register is written, a read port that selects it shows the previous contents; it shows the new word only after the edge.
- R6: When `rst` and `wr_en` are both high at the same edge, reset takes priority and the targeted register ends at zero.
- R7: The two read ports are independent. They may select the same register, or the register under write, with no conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Index of the register to write |
| wr_data | input | 16 | Word to store |
| rdA_sel | input | 3 | Index read on port A |
| rdA_data | output | 16 | Contents of register rdA_sel |
| rdB_sel | input | 3 | Index read on port B |
| rdB_data | output | 16 | Contents of register rdB_sel |

## Verification
The hardest case to reach from the ports is the absence of bypass. It needs a read port aimed at the very register being written, and the port must be observed in the short window between driving the write and the clock edge. The stimulus sets the write select and a read select to the same index with fresh data, then samples the read port just before the edge and again just after it. Reset priority is reached by asserting reset and write together on a register already holding a non-zero word. The bench also sweeps all 64 read-select pairs.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
    localparam int unsigned RB_DEF_WIDTH = 16;
    localparam int unsigned RB_DEF_DEPTH = 8;

    // condition of one storage entry, used for documentation of transitions
    typedef enum logic [1:0] {
        ENT_CLEARED = 2'd0,
        ENT_LOADED  = 2'd1
    } entry_state_e;
endpackage

// File: rtl/regbank_cell.sv
module regbank_cell #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_r <= '0;
        end else if (load) begin
            q_r <= d;
        end
    end

    assign q = q_r;

    // R3: no load means the value is held
    a_r3_hold_unloaded: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && !$past(rst)) |-> (q == $past(q)));
endmodule

// File: rtl/regbank_wdec.sv
module regbank_wdec #(
    parameter int unsigned DEPTH = 8,
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    output logic [DEPTH-1:0] load_vec
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_dec
        assign load_vec[gi] = wr_en && (wr_sel == SEL_W'(gi));
    end

    // R2/R3: at most one register is loaded per edge
    a_r3_one_load: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_vec));
endmodule

// File: rtl/regbank_rmux.sv
module regbank_rmux #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned DEPTH = 8,
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0][WIDTH-1:0] bank,
    input  logic [SEL_W-1:0]            sel,
    output logic [WIDTH-1:0]            dout
);
    always_comb begin
        dout = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel == SEL_W'(i)) begin
                dout = bank[i];
            end
        end
    end
endmodule

// File: rtl/regbank_2r1w.sv
module regbank_2r1w
    import regbank_pkg::*;
#(
    parameter int unsigned WIDTH = RB_DEF_WIDTH,
    parameter int unsigned DEPTH = RB_DEF_DEPTH,
    localparam int unsigned SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [SEL_W-1:0] rdA_sel,
    output logic [WIDTH-1:0] rdA_data,
    input  logic [SEL_W-1:0] rdB_sel,
    output logic [WIDTH-1:0] rdB_data
);
    logic [DEPTH-1:0]            load_vec;
    logic [DEPTH-1:0][WIDTH-1:0] bank;

    regbank_wdec #(.DEPTH(DEPTH)) u_wdec (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .load_vec (load_vec)
    );

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
        regbank_cell #(.WIDTH(WIDTH)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .load (load_vec[gi]),
            .d    (wr_data),
            .q    (bank[gi])
        );
    end

    regbank_rmux #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rmux_a (
        .bank (bank),
        .sel  (rdA_sel),
        .dout (rdA_data)
    );

    regbank_rmux #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rmux_b (
        .bank (bank),
        .sel  (rdB_sel),
        .dout (rdB_data)
    );

    // R2: a write lands in the selected register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst)) |-> (bank[$past(wr_sel)] == $past(wr_data)));

    // R1/R6: the cycle after reset is released, the whole bank is zero
    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (bank == '0));
endmodule

// File: tb/tb_regbank_2r1w.sv
`timescale 1ns/1ps
module tb_regbank_2r1w;
    localparam int W = 16;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic         wr_en;
    logic [2:0]   wr_sel;
    logic [W-1:0] wr_data;
    logic [2:0]   rdA_sel, rdB_sel;
    logic [W-1:0] rdA_data, rdB_data;

    logic [W-1:0] model [N];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    regbank_2r1w dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rdA_sel(rdA_sel), .rdA_data(rdA_data), .rdB_sel(rdB_sel), .rdB_data(rdB_data)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < N; a++) begin
            for (int b = 0; b < N; b++) begin
                rdA_sel = 3'(a);
                rdB_sel = 3'(b);
                #0.2;
                check(req, rdA_data, model[a]);
                check(req, rdB_data, model[b]);
            end
        end
    endtask

    function automatic logic [W-1:0] pat(input int i, input int round);
        return W'(16'h5A3C ^ (i * 16'h1111) ^ (round * 16'h0F01));
    endfunction

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rdA_sel = '0; rdB_sel = '0;
        for (int i = 0; i < N; i++) model[i] = '0;
        tick(); tick();
        // R1: reset state
        sweep("R1");
        rst = 1'b0;
        // R2/R4/R7: fill and sweep, two rounds
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < N; i++) begin
                wr_en = 1'b1; wr_sel = 3'(i); wr_data = pat(i, r);
                tick();
                model[i] = pat(i, r);
            end
            wr_en = 1'b0;
            sweep("R2_R4_R7");
        end
        // R3: wr_en low with changing data
        for (int i = 0; i < N; i++) begin
            wr_en = 1'b0; wr_sel = 3'(i); wr_data = 16'hDEAD;
            tick();
        end
        sweep("R3");
        // R3: single write leaves others intact
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 16'h1234;
        tick();
        model[3] = 16'h1234;
        wr_en = 1'b0;
        sweep("R3");
        // R5: no bypass
        for (int i = 0; i < N; i++) begin
            wr_en = 1'b1; wr_sel = 3'(i); wr_data = ~pat(i, 7);
            rdA_sel = 3'(i); rdB_sel = 3'(i);
            #0.5;
            check("R5", rdA_data, model[i]);
            check("R5", rdB_data, model[i]);
            tick();
            model[i] = ~pat(i, 7);
            check("R5", rdA_data, model[i]);
            check("R5", rdB_data, model[i]);
        end
        wr_en = 1'b0;
        // R6: reset wins over write
        rst = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 16'hBEEF;
        tick();
        rst = 1'b0; wr_en = 1'b0;
        for (int i = 0; i < N; i++) model[i] = '0;
        sweep("R6");
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule